// File: doc/BRIEF.md
# Eight-Function 32-bit Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit. Two operand words enter, a three-bit function code picks one of eight operations, and the chosen result leaves on the same cycle together with a flag that marks an all-zero result. It is intended to sit between operand registers and a result register in a simple datapath. The block itself holds no state and takes no clock.

Sum and difference come from one shared adder. For a difference, the second operand is complemented and a carry of one is injected. Shifts are logical and move the first operand by a distance taken from the low bits of the second operand. The remaining four codes are bitwise logic. A parameter selects how the shifter is built: either a staged barrel of multiplexers or the plain shift operators.

Top module: `alu_core`

## Requirements
- R1: Function code 3'b000 drives res_o with fn_a_i plus b_i, wrapped modulo 2^WIDTH, with no carry or overflow output.
- R2: Function code 3'b001 drives res_o with a_i minus b_i, wrapped modulo 2^WIDTH. The result is formed in the same adder as R1, from the complement of b_i and a carry-in of one.
- R3: Function code 3'b010 drives res_o with a_i shifted left by b_i[4:0] places, and the vacated low bits read zero.
- R4: Function code 3'b011 drives res_o with a_i shifted right logically by b_i[4:0] places, and the vacated high bits read zero.
- R5: Function codes 3'b100, 3'b101, 3'b110 and 3'b111 drive res_o with the bitwise AND, OR, XOR and NOR of a_i and b_i, in that order.
- R6: zero_o is 1 exactly when all 32 bits of res_o are 0, for every function code.
- R7: During a shift, bits b_i[31:5] have no effect on res_o. A shift distance of 0 (for example b_i = 32'h20) returns a_i unchanged.
- R8: res_o and zero_o follow a change of a_i, b_i or fn_i without any clock edge, and every one of the eight codes yields a defined value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fn_i | input | 3 | Function select, encoded as in R1 to R5 |
| a_i | input | 32 | First operand; this is the word that gets shifted |
| b_i | input | 32 | Second operand; its low 5 bits give the shift distance |
| res_o | output | 32 | Result of the selected function |
| zero_o | output | 1 | High when res_o is all zeros |

## Verification
The bench aims at the wrap points of the shared adder. Adding one to all-ones must give zero and raise the flag, and subtracting one from zero must give all-ones. An adder that drops the injected carry would be off by one on every difference. An adder that forgets the complement would add instead of subtract. Shift vectors use distances 0 and 31 and set the upper bits of b_i. A shifter that reads too many bits of b_i would flush the word to zero. Swapped directions, or a fill with ones, show up as wrong end bits. Logic codes are paired so that a swapped AND/OR or XOR/NOR mapping gives a visibly different word. The all-zero results check that the flag follows the final result and not one internal path.

// File: rtl/alu_pkg.sv
package alu_pkg;

   typedef enum logic [2:0] {
      FN_ADD = 3'b000,
      FN_SUB = 3'b001,
      FN_SHL = 3'b010,
      FN_SHR = 3'b011,
      FN_AND = 3'b100,
      FN_OR  = 3'b101,
      FN_XOR = 3'b110,
      FN_NOR = 3'b111
   } alu_fn_e;

   typedef enum logic [1:0] {
      LG_AND = 2'b00,
      LG_OR  = 2'b01,
      LG_XOR = 2'b10,
      LG_NOR = 2'b11
   } logic_sel_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             sub_i,
   output logic [WIDTH-1:0] sum_o
);

   logic [WIDTH-1:0] b_eff;
   logic [WIDTH-1:0] carry_in;
   logic [WIDTH-1:0] sum_v;

   always_comb begin
      b_eff    = sub_i ? ~b_i : b_i;
      carry_in = {{(WIDTH-1){1'b0}}, sub_i};
      sum_v    = a_i + b_eff + carry_in;
      sum_o    = sum_v;
      if (sub_i) begin
         AST_SUB_INVERSE: assert (sum_v + b_i == a_i); // R2
      end else begin
         AST_ADD_INVERSE: assert (sum_v - b_i == a_i); // R1
      end
   end

endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
   parameter int WIDTH  = 32,
   parameter bit BARREL = 1'b1,
   localparam int SHW   = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] val_i,
   input  logic [SHW-1:0]   amt_i,
   input  logic             right_i,
   output logic [WIDTH-1:0] res_o
);

   logic [WIDTH-1:0] left_w;
   logic [WIDTH-1:0] right_w;

   if (BARREL) begin : g_barrel
      logic [WIDTH-1:0] lstg [SHW+1];
      logic [WIDTH-1:0] rstg [SHW+1];
      assign lstg[0] = val_i;
      assign rstg[0] = val_i;
      for (genvar k = 0; k < SHW; k++) begin : g_stage
         localparam int STEP = 1 << k;
         assign lstg[k+1] = amt_i[k] ?
            {lstg[k][WIDTH-1-STEP:0], {STEP{1'b0}}} : lstg[k];
         assign rstg[k+1] = amt_i[k] ?
            {{STEP{1'b0}}, rstg[k][WIDTH-1:STEP]} : rstg[k];
      end
      assign left_w  = lstg[SHW];
      assign right_w = rstg[SHW];
   end else begin : g_operator
      assign left_w  = val_i << amt_i;
      assign right_w = val_i >> amt_i;
   end

   always_comb begin
      res_o = right_i ? right_w : left_w;
      if (right_i) begin
         AST_SHR_NO_NEW_ONES: assert ($countones(right_w) <= $countones(val_i)); // R4
      end else begin
         AST_SHL_NO_NEW_ONES: assert ($countones(left_w) <= $countones(val_i)); // R3
      end
      if (amt_i == '0) begin
         AST_SHIFT_ZERO_PASS: assert (res_o == val_i); // R7
      end
   end

endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [1:0]       sel_i,
   output logic [WIDTH-1:0] res_o
);
   import alu_pkg::*;

   logic [WIDTH-1:0] v_and, v_or, v_xor, v_nor;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign v_and[i] = a_i[i] & b_i[i];
      assign v_or[i]  = a_i[i] | b_i[i];
      assign v_xor[i] = a_i[i] ^ b_i[i];
      assign v_nor[i] = ~(a_i[i] | b_i[i]);
   end

   always_comb begin
      unique case (logic_sel_e'(sel_i))
         LG_AND:  res_o = v_and;
         LG_OR:   res_o = v_or;
         LG_XOR:  res_o = v_xor;
         default: res_o = v_nor;
      endcase
      AST_XOR_SPLIT:  assert (v_xor == (v_or & ~v_and)); // R5
      AST_NOR_DISJOINT: assert ((v_nor & v_or) == '0); // R5
   end

endmodule

// File: rtl/alu_core.sv
module alu_core #(
   parameter int WIDTH  = 32,
   parameter bit BARREL = 1'b1
) (
   input  logic [2:0]       fn_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] res_o,
   output logic             zero_o
);
   import alu_pkg::*;

   localparam int SHW = $clog2(WIDTH);

   if (WIDTH < 2) begin : g_bad_width
      $error("alu_core: WIDTH must be at least 2");
   end
   if ((1 << SHW) != WIDTH) begin : g_bad_pow2
      $error("alu_core: WIDTH must be a power of two");
   end

   logic [WIDTH-1:0] arith_w, shift_w, logic_w;

   alu_addsub #(.WIDTH(WIDTH)) u_addsub (
      .a_i   (a_i),
      .b_i   (b_i),
      .sub_i (fn_i[0]),
      .sum_o (arith_w)
   );

   alu_shift #(.WIDTH(WIDTH), .BARREL(BARREL)) u_shift (
      .val_i   (a_i),
      .amt_i   (b_i[SHW-1:0]),
      .right_i (fn_i[0]),
      .res_o   (shift_w)
   );

   alu_logic #(.WIDTH(WIDTH)) u_logic (
      .a_i   (a_i),
      .b_i   (b_i),
      .sel_i (fn_i[1:0]),
      .res_o (logic_w)
   );

   always_comb begin
      if (fn_i[2])      res_o = logic_w;
      else if (fn_i[1]) res_o = shift_w;
      else              res_o = arith_w;
      zero_o = ~|res_o;
      if (zero_o && alu_fn_e'(fn_i) == FN_SUB) begin
         AST_ZERO_SUB_EQUAL: assert (a_i == b_i); // R6
      end
      if (zero_o && alu_fn_e'(fn_i) == FN_OR) begin
         AST_ZERO_OR_EMPTY: assert ((a_i == '0) && (b_i == '0)); // R6
      end
   end

endmodule

// File: tb/tb_alu_core.sv
module tb_alu_core;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  fn;
   logic [31:0] a, b;
   logic [31:0] res;
   logic        zero;
   int          total = 0;
   int          fails = 0;
   int          cycles = 0;

   always #10 clk = ~clk;

   alu_core dut (.fn_i(fn), .a_i(a), .b_i(b), .res_o(res), .zero_o(zero));

   typedef struct packed {
      logic [2:0]  fn;
      logic [31:0] a;
      logic [31:0] b;
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VECS [NV] = '{
      '{3'b000, 32'h00000005, 32'h00000003, 32'h00000008, 4'd1},
      '{3'b000, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 4'd1},
      '{3'b001, 32'h0000000A, 32'h00000003, 32'h00000007, 4'd2},
      '{3'b001, 32'h00000000, 32'h00000001, 32'hFFFFFFFF, 4'd2},
      '{3'b001, 32'h12345678, 32'h12345678, 32'h00000000, 4'd2},
      '{3'b010, 32'h00000001, 32'h0000001F, 32'h80000000, 4'd3},
      '{3'b010, 32'h00000003, 32'h00000024, 32'h00000030, 4'd7},
      '{3'b011, 32'h80000000, 32'h0000001F, 32'h00000001, 4'd4},
      '{3'b011, 32'hF0000000, 32'hFFFFFFE4, 32'h0F000000, 4'd7},
      '{3'b010, 32'h0000ABCD, 32'h00000020, 32'h0000ABCD, 4'd7},
      '{3'b100, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 4'd5},
      '{3'b101, 32'hF0F0F0F0, 32'h0F0F0F0F, 32'hFFFFFFFF, 4'd5},
      '{3'b110, 32'hAAAAAAAA, 32'hAAAAAAAA, 32'h00000000, 4'd5},
      '{3'b110, 32'h12345678, 32'hFFFFFFFF, 32'hEDCBA987, 4'd5},
      '{3'b111, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, 4'd5},
      '{3'b111, 32'hF0F0F0F0, 32'h0F0F0F0F, 32'h00000000, 4'd5},
      '{3'b100, 32'h12345678, 32'h00000000, 32'h00000000, 4'd5}
   };

   function automatic string req_name(input int idx);
      case (idx)
         1: return "R1";
         2: return "R2";
         3: return "R3";
         4: return "R4";
         5: return "R5";
         6: return "R6";
         7: return "R7";
         default: return "R8";
      endcase
   endfunction

   function automatic logic [31:0] model(input logic [2:0] f, input logic [31:0] x,
                                         input logic [31:0] y);
      int unsigned d = y % 32;
      case (f)
         3'b000: return x + y;
         3'b001: return x - y;
         3'b010: return x << d;
         3'b011: return x >> d;
         3'b100: return x & y;
         3'b101: return x | y;
         3'b110: return x ^ y;
         default: return ~(x | y);
      endcase
   endfunction

   task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic drive(input logic [2:0] f, input logic [31:0] x, input logic [31:0] y);
      @(negedge clk);
      fn = f; a = x; b = y;
      #5;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000) begin
         fails++; total++;
         $display("FAIL R8 watchdog actual=%0d expected<=%0d", cycles, 50000);
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      fn = 3'b000; a = '0; b = '0;
      repeat (2) @(posedge clk);
      #5;
      check("R6", {31'd0, zero}, 32'd1);      // reset-time state: 0+0 flags zero
      check("R1", res, 32'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         drive(VECS[i].fn, VECS[i].a, VECS[i].b);
         check(req_name(int'(VECS[i].req)), res, VECS[i].exp);
         check("R6", {31'd0, zero}, {31'd0, VECS[i].exp == 32'd0});
      end

      for (int f = 0; f < 8; f++) begin
         for (int k = 0; k < 4; k++) begin
            logic [31:0] x = $urandom;
            logic [31:0] y = $urandom;
            drive(3'(f), x, y);
            case (f)
               0: check("R1", res, model(3'(f), x, y));
               1: check("R2", res, model(3'(f), x, y));
               2: check("R3", res, model(3'(f), x, y));
               3: check("R4", res, model(3'(f), x, y));
               default: check("R5", res, model(3'(f), x, y));
            endcase
         end
      end

      // R7: upper bits of b change, shift result must not
      drive(3'b010, 32'h00F0000F, 32'h00000008);
      check("R7", res, 32'hF0000F00);
      drive(3'b010, 32'h00F0000F, 32'hFFFFFFE8);
      check("R7", res, 32'hF0000F00);

      // R8: two input changes inside one low clock phase, no edge between
      @(negedge clk);
      fn = 3'b101; a = 32'h0000FF00; b = 32'h000000FF;
      #2;
      check("R8", res, 32'h0000FFFF);
      fn = 3'b001; a = 32'h00000010; b = 32'h00000010;
      #2;
      check("R8", res, 32'h00000000);
      check("R6", {31'd0, zero}, 32'd1);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule